// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides one unsigned WIDTH-bit operand by another over several clock cycles. One partial-remainder update is done per cycle. A pulse on `start` while the unit is idle captures both operands. The unit then runs one iteration per dividend bit. Each iteration shifts the partial remainder and the quotient register left together. It then subtracts or adds the divisor, and the choice depends only on the sign of the previous partial remainder. A negative intermediate value is never undone within the same step. Instead, the next iteration adds the divisor back as part of its own work.

After the last iteration, one extra correction cycle adds the divisor once if the partial remainder is still negative. This makes the remainder non-negative. The quotient and remainder then appear on the outputs, together with a one-cycle `done` pulse, and they stay unchanged until the next operation is accepted. If the divisor is zero, the unit skips the iterations and raises a flag instead. The partial remainder register is one bit wider than the operands, so its sign is always available. A parameter selects how the shared add/subtract unit is built.

Top module: `seq_nr_divider`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done` and `div_by_zero` are 0, and `quotient` and `remainder` are 0.
- R2: `start` is accepted when `busy` is 0. With a non-zero divisor, `busy` is 1 for exactly WIDTH+1 cycles, beginning the cycle after the accepting edge. `done` is 1 for the single cycle that follows, and `busy` is 0 during that cycle.
- R3: When `done` rises after a non-zero-divisor operation, `quotient` equals floor(dividend/divisor) and `remainder` equals dividend mod divisor. Both are read as unsigned numbers. For example, 7 divided by 5 gives 1 remainder 2.
- R4: R3 holds across the whole unsigned range. This includes operands with the top bit set, a zero dividend, a divisor larger than the dividend, and a divisor of 1.
- R5: If the divisor is 0 when `start` is accepted, then `done` and `div_by_zero` are 1 in the next cycle and `busy` stays 0. In that case `quotient` is all ones and `remainder` equals the dividend. `div_by_zero` keeps its value until the next accepted start, which clears it when that divisor is non-zero.
- R6: `start` pulses, and changes on the operand inputs, while `busy` is 1 are ignored. The running operation still produces the result of the operands captured when it was accepted.
- R7: A `start` presented in the same cycle that `done` is 1 is accepted. Operations issued back to back this way each give correct results.
- R8: While idle with `start` low, `quotient`, `remainder` and `div_by_zero` hold their values whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| dividend | input | WIDTH | Unsigned dividend |
| divisor | input | WIDTH | Unsigned divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| quotient | output | WIDTH | Quotient |
| remainder | output | WIDTH | Remainder |
| div_by_zero | output | 1 | Last accepted operation had a zero divisor |

## Verification
Several properties are checked on every clock cycle:
- After the correction cycle, the partial remainder is non-negative and smaller than the stored divisor.
- The correction cycle always follows an iteration, and the iteration counter never passes WIDTH.
- `done` never coincides with `busy`, and a zero-divisor acceptance is followed by the flagged completion.
- An idle unit leaves its result registers untouched.

Only the bench scenarios can show that the arithmetic values are right. These scenarios cover corner operands, ignored starts during a run, back-to-back issue, and randomized operands. The bench compares busy, done, flag and held results against a behavioural model on every cycle.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_STEP = 2'd1,
      ST_FIX  = 2'd2
   } nrdiv_state_e;

   localparam int ADDER_BEHAVIOURAL = 0;
   localparam int ADDER_RIPPLE      = 1;

endpackage

// File: rtl/nrdiv_addsub.sv
module nrdiv_addsub #(
   parameter int W    = 9,
   parameter int ARCH = 0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] y
);
   import nrdiv_pkg::*;

   logic [W-1:0] b_eff;
   assign b_eff = b ^ {W{sub}};

   generate
      if (ARCH == ADDER_RIPPLE) begin : g_ripple
         logic [W-1:0] carry;
         assign carry[0] = sub;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign y[i] = a[i] ^ b_eff[i] ^ carry[i];
            if (i < W - 1) begin : g_cy
               assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
            end
         end
      end else begin : g_behav
         assign y = a + b_eff + {{(W-1){1'b0}}, sub};
      end
   endgenerate

endmodule

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl #(
   parameter int WIDTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic zero_div,
   output logic load_en,
   output logic load_zero,
   output logic step_en,
   output logic fix_en,
   output logic busy,
   output logic done,
   output logic dbz
);
   import nrdiv_pkg::*;

   localparam int CW = $clog2(WIDTH + 1);
   localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

   nrdiv_state_e state;
   logic [CW-1:0] step_cnt;
   logic          accept;

   assign accept    = start && (state == ST_IDLE);
   assign load_en   = accept && !zero_div;
   assign load_zero = accept && zero_div;
   assign step_en   = (state == ST_STEP);
   assign fix_en    = (state == ST_FIX);
   assign busy      = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         step_cnt <= '0;
         done     <= 1'b0;
         dbz      <= 1'b0;
      end else begin
         done <= fix_en || load_zero;
         if (accept) dbz <= zero_div;
         case (state)
            ST_IDLE: begin
               if (load_en) begin
                  state    <= ST_STEP;
                  step_cnt <= '0;
               end
            end
            ST_STEP: begin
               step_cnt <= step_cnt + 1'b1;
               if (step_cnt == LAST_STEP) state <= ST_FIX;
            end
            ST_FIX:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R2: the counter never runs past the iteration count
   a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |-> (step_cnt <= LAST_STEP));

   // R2: correction is always preceded by an iteration
   a_r2_fix_after_step: assert property (@(posedge clk) disable iff (!rst_n)
      fix_en |-> $past(step_en));

   // R2: completion is never reported while busy
   a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R6: a start seen mid-run does not disturb the sequence
   a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && start) |=> (step_en || fix_en));

   // R5: zero divisor finishes at once with the flag set
   a_r5_zero_path: assert property (@(posedge clk) disable iff (!rst_n)
      load_zero |=> (done && dbz && !busy));

endmodule

// File: rtl/nrdiv_dp.sv
module nrdiv_dp #(
   parameter int WIDTH    = 8,
   parameter int ADD_ARCH = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic             load_zero,
   input  logic             step_en,
   input  logic             fix_en,
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic [WIDTH-1:0] quotient,
   output logic [WIDTH-1:0] remainder
);
   localparam int AW = WIDTH + 1;

   logic [AW-1:0]    acc;
   logic [WIDTH-1:0] quo;
   logic [WIDTH-1:0] dvs;
   logic [AW-1:0]    shifted;
   logic [AW-1:0]    op_a;
   logic [AW-1:0]    op_b;
   logic             op_sub;
   logic [AW-1:0]    sum;

   assign shifted = {acc[AW-2:0], quo[WIDTH-1]};
   assign op_a    = fix_en ? acc : shifted;
   assign op_b    = {1'b0, dvs};
   assign op_sub  = fix_en ? 1'b0 : ~acc[AW-1];

   nrdiv_addsub #(.W(AW), .ARCH(ADD_ARCH)) u_addsub (
      .a   (op_a),
      .b   (op_b),
      .sub (op_sub),
      .y   (sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         quo <= '0;
         dvs <= '0;
      end else if (load_en) begin
         acc <= '0;
         quo <= dividend;
         dvs <= divisor;
      end else if (load_zero) begin
         acc <= {1'b0, dividend};
         quo <= '1;
         dvs <= divisor;
      end else if (step_en) begin
         acc <= sum;
         quo <= {quo[WIDTH-2:0], ~sum[AW-1]};
      end else if (fix_en) begin
         if (acc[AW-1]) acc <= sum;
      end
   end

   assign quotient  = quo;
   assign remainder = acc[WIDTH-1:0];

   // R3: after correction the remainder is non-negative and below the divisor
   a_r3_rem_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fix_en) |-> (!acc[AW-1] && (acc < {1'b0, dvs})));

   // R8: idle cycles leave the result registers untouched
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !load_zero && !step_en && !fix_en) |=> ($stable(acc) && $stable(quo)));

endmodule

// File: rtl/seq_nr_divider.sv
module seq_nr_divider #(
   parameter int WIDTH    = 8,
   parameter int ADD_ARCH = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] quotient,
   output logic [WIDTH-1:0] remainder,
   output logic             div_by_zero
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("seq_nr_divider: WIDTH must be at least 2");
      end
      if (ADD_ARCH != 0 && ADD_ARCH != 1) begin : g_bad_arch
         $error("seq_nr_divider: ADD_ARCH must be 0 or 1");
      end
   endgenerate

   logic zero_div;
   logic load_en, load_zero, step_en, fix_en;

   assign zero_div = (divisor == '0);

   nrdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .zero_div  (zero_div),
      .load_en   (load_en),
      .load_zero (load_zero),
      .step_en   (step_en),
      .fix_en    (fix_en),
      .busy      (busy),
      .done      (done),
      .dbz       (div_by_zero)
   );

   nrdiv_dp #(.WIDTH(WIDTH), .ADD_ARCH(ADD_ARCH)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (load_en),
      .load_zero (load_zero),
      .step_en   (step_en),
      .fix_en    (fix_en),
      .dividend  (dividend),
      .divisor   (divisor),
      .quotient  (quotient),
      .remainder (remainder)
   );

   // R5: a flagged completion always stems from an idle start with zero divisor
   a_r5_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (done && div_by_zero) |-> $past(start && !busy && (divisor == '0)));

endmodule

// File: tb/seq_nr_divider_test.sv
module seq_nr_divider_test;
   localparam int  W          = 8;
   localparam time CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] dividend = '0;
   logic [W-1:0] divisor = '0;
   wire          busy, done, dbz;
   wire  [W-1:0] quotient, remainder;

   seq_nr_divider #(.WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
      .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
      .div_by_zero(dbz)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int           vec = 0, bad = 0, cyc = 0;
   bit           finished = 0;
   string        tag = "R1";

   // behavioural reference state
   int           m_cnt = 0;
   bit           m_busy = 0, m_done = 0, m_dbz = 0;
   logic [W-1:0] m_q = '0, m_r = '0, p_q = '0, p_r = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_busy = 0; m_done = 0; m_dbz = 0; m_q = '0; m_r = '0;
      end else begin
         m_done = 0;
         if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
               m_busy = 0; m_done = 1; m_q = p_q; m_r = p_r;
            end
         end else if (start) begin
            if (divisor == 0) begin
               m_done = 1; m_dbz = 1; m_q = '1; m_r = dividend;
            end else begin
               m_dbz = 0; m_busy = 1; m_cnt = W + 1;
               p_q = dividend / divisor;
               p_r = dividend % divisor;
            end
         end
      end
   end

   task automatic chk(string what, logic [W-1:0] act, logic [W-1:0] exp);
      vec++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (!finished && cyc >= 2) begin
         chk("busy (R2)", W'(busy), W'(m_busy));
         chk("done (R2)", W'(done), W'(m_done));
         chk("div_by_zero (R5)", W'(dbz), W'(m_dbz));
         if (!m_busy) begin
            chk("quotient (R3)", quotient, m_q);
            chk("remainder (R3)", remainder, m_r);
         end
      end
   end

   task automatic finish_up();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_up();
      end
   end

   // caller stands at a negedge
   task automatic issue(logic [W-1:0] a, logic [W-1:0] b);
      while (busy) @(negedge clk);
      dividend = a; divisor = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
   endtask

   task automatic run_op(logic [W-1:0] a, logic [W-1:0] b);
      issue(a, b);
      wait_done();
      @(negedge clk);
   endtask

   initial begin
      // R1: reset state
      tag = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R3: basic quotients, including final negative-remainder correction
      tag = "R3";
      run_op(8'd7, 8'd5);
      run_op(8'd6, 8'd4);
      run_op(8'd100, 8'd7);
      run_op(8'd9, 8'd3);

      // R4: range corners
      tag = "R4";
      run_op(8'd255, 8'd1);
      run_op(8'd255, 8'd255);
      run_op(8'd0, 8'd9);
      run_op(8'd3, 8'd200);
      run_op(8'd128, 8'd3);
      run_op(8'd255, 8'd2);
      run_op(8'd1, 8'd255);
      run_op(8'd254, 8'd255);
      run_op(8'd200, 8'd128);

      // R5: zero divisor, back-to-back, then cleared by a normal op
      tag = "R5";
      issue(8'd77, 8'd0);
      wait_done();
      issue(8'd13, 8'd0);
      wait_done();
      @(negedge clk);
      repeat (2) @(negedge clk);
      run_op(8'd50, 8'd6);

      // R6: start pulses and operand changes while running are ignored
      tag = "R6";
      issue(8'd201, 8'd10);
      for (int k = 0; k < 3; k++) begin
         dividend = 8'(k * 31 + 5); divisor = 8'(k + 1); start = 1'b1;
         @(negedge clk);
      end
      start = 1'b0;
      dividend = 8'd0; divisor = 8'd0;
      wait_done();
      @(negedge clk);

      // R7: issue in the same cycle as done
      tag = "R7";
      issue(8'd250, 8'd7);
      for (int k = 0; k < 5; k++) begin
         wait_done();
         issue(8'(k * 47 + 3), 8'(k * 13 + 1));
      end
      wait_done();
      issue(8'd5, 8'd0);
      wait_done();
      issue(8'd90, 8'd9);
      wait_done();
      @(negedge clk);

      // R8: idle outputs hold while inputs wiggle
      tag = "R8";
      for (int k = 0; k < 6; k++) begin
         dividend = 8'(k * 41); divisor = 8'(k * 3);
         @(negedge clk);
      end

      // R3/R4: random operands
      tag = "R3";
      for (int k = 0; k < 300; k++) begin
         logic [W-1:0] ra, rb;
         ra = W'($urandom);
         rb = W'($urandom);
         if (k % 37 == 0) rb = '0;
         run_op(ra, rb);
      end

      repeat (3) @(negedge clk);
      finish_up();
   end

endmodule